// File: doc/BRIEF.md
# Double-Buffered LED Brightness Controller

This block drives one pulse-width-modulated output line per LED channel. A host writes byte-wide registers through a plain synchronous port made of an address, a data byte and a write strobe. Brightness bytes land in a pending copy first. A write to a commit register moves every pending byte into the active copy in the same clock edge. This lets the host stage a whole frame of brightness changes and release them together.

Three controls can keep the outputs dark even when a channel has a non-zero active brightness: a shutdown register, a global mute register and a per-channel enable register. A write to a clear register returns the whole register file to its power-up state.

The output mode is held by a four-state machine:

| State | Meaning |
|---|---|
| DARK | Shutdown, not muted |
| DARK_MUTED | Shutdown and muted |
| LIVE | Running |
| MUTED | Running but muted |

Only LIVE lets pulses through. The transitions are:

- **wake**: DARK to LIVE, or DARK_MUTED to MUTED. Taken on a shutdown-register write with bit 0 = 1.
- **sleep**: the reverse of wake. Taken on a shutdown-register write with bit 0 = 0.
- **mute**: DARK to DARK_MUTED, or LIVE to MUTED. Taken on a global-register write with bit 0 = 1.
- **unmute**: the reverse of mute. Taken on a global-register write with bit 0 = 0.
- **clear**: any state to DARK. Taken on a write to the clear register.

Top module: `led_pwm_ctrl`

## Requirements
- R1: With default ordering, the brightness byte of channel n (1-based) is written at address 0x01 + (n − 1).
- R2: With parameter REVERSED = 1, the brightness byte of channel n is written at address 0x01 + (NUM_CH − n).
- R3: Brightness writes change only the pending copy. A write of any value to address 0x25 copies every pending byte into the active copy on the same edge. Later brightness writes stay pending until the next such write.
- R4: Several brightness writes followed by one commit give the same outputs as a commit after each brightness write.
- R5: All channels share a free-running 8-bit counter. A channel's output is high while the counter is below its active byte. Over any 256 consecutive cycles the output is high for exactly that many cycles: 0 is always off and 255 is high 255 cycles.
- R6: Address 0x00 is the shutdown register. A write with bit 0 = 0 forces every output low. A write with bit 0 = 1 selects normal running. The other bits are ignored.
- R7: Address 0x26 + (n − 1) holds channel n's enable in bit 0, and the other bits are ignored. A disabled channel's output stays low.
- R8: Address 0x4A is the global register. Bit 0 = 1 forces every output low. Bit 0 = 0 (for example 0x00, or 0xFE) selects normal running, and the other bits are ignored.
- R9: A write of any value to address 0x4F returns every register to its default: pending, active, enables, shutdown and global.
- R10: After reset the block is shut down (DARK), all pending and active bytes are zero, all enables are zero and the global register is zero.
- R11: Writes to unmapped addresses, such as 0x4B–0x4E and 0x50–0xFF, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | AW (8) | Register address |
| wdata_i | input | DW (8) | Write data |
| pwm_o | output | NUM_CH (36) | One pulse-width-modulated line per channel |

## Verification
The bench probes the following corner cases and the failure each would expose:

- **Staged writes:** a design that let staged writes leak into the active copy would light channels before the commit.
- **Commit order:** a design that committed only the last-written channel would break the equivalence between one batch commit and per-write commits.
- **Duty extremes:** at duties 0, 1 and 255, an off-by-one comparator shows up as a high count of 1, 2 or 256.
- **Reversed mapping:** a second, reversed instance would light the wrong line if the address mirroring were wrong.
- **Hidden mute:** muting while shut down and then waking must stay dark. A design that held only one of the two control bits would light up.
- **Clear register:** a clear that reset only the active copy would let a later commit bring back old pending bytes.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    localparam int ADDR_SHDN      = 8'h00;
    localparam int ADDR_DUTY_BASE = 8'h01;
    localparam int ADDR_COMMIT    = 8'h25;
    localparam int ADDR_EN_BASE   = 8'h26;
    localparam int ADDR_GLOBAL    = 8'h4A;
    localparam int ADDR_CLEAR     = 8'h4F;

    typedef enum logic [2:0] {
        K_NONE,
        K_SHDN,
        K_DUTY,
        K_COMMIT,
        K_ENABLE,
        K_GLOBAL,
        K_CLEAR
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_DARK,
        ST_DARK_MUTED,
        ST_LIVE,
        ST_MUTED
    } mode_e;

endpackage

// File: rtl/led_reg_decode.sv
module led_reg_decode
    import led_pwm_pkg::*;
#(
    parameter int NUM_CH    = 36,
    parameter int AW        = 8,
    parameter bit REVERSED  = 1'b0,
    parameter int SHDN_ADDR = ADDR_SHDN,
    parameter int DUTY_BASE = ADDR_DUTY_BASE,
    parameter int COMMIT_ADDR = ADDR_COMMIT,
    parameter int EN_BASE   = ADDR_EN_BASE,
    parameter int GLOBAL_ADDR = ADDR_GLOBAL,
    parameter int CLEAR_ADDR  = ADDR_CLEAR
) (
    input  logic [AW-1:0]     addr_i,
    output reg_kind_e         kind_o,
    output logic [NUM_CH-1:0] duty_sel_o,
    output logic [NUM_CH-1:0] en_sel_o
);

    // Per-channel address match; REVERSED mirrors the brightness block only.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int DUTY_OFS = REVERSED ? (NUM_CH - 1 - i) : i;
        assign duty_sel_o[i] = (addr_i == AW'(DUTY_BASE + DUTY_OFS));
        assign en_sel_o[i]   = (addr_i == AW'(EN_BASE + i));
    end

    always_comb begin
        if (addr_i == AW'(SHDN_ADDR))
            kind_o = K_SHDN;
        else if (addr_i == AW'(COMMIT_ADDR))
            kind_o = K_COMMIT;
        else if (addr_i == AW'(GLOBAL_ADDR))
            kind_o = K_GLOBAL;
        else if (addr_i == AW'(CLEAR_ADDR))
            kind_o = K_CLEAR;
        else if (|duty_sel_o)
            kind_o = K_DUTY;
        else if (|en_sel_o)
            kind_o = K_ENABLE;
        else
            kind_o = K_NONE;
    end

endmodule

// File: rtl/led_chan_bank.sv
module led_chan_bank #(
    parameter int NUM_CH = 36,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 commit_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [NUM_CH-1:0]    duty_we_i,
    input  logic [NUM_CH-1:0]    en_we_i,
    output logic [NUM_CH*DW-1:0] pending_o,
    output logic [NUM_CH*DW-1:0] active_o,
    output logic [NUM_CH-1:0]    en_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DW-1:0] pend_q;
        logic [DW-1:0] act_q;
        logic          en_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= '0;
                act_q  <= '0;
                en_q   <= 1'b0;
            end else if (clear_i) begin
                pend_q <= '0;
                act_q  <= '0;
                en_q   <= 1'b0;
            end else begin
                if (duty_we_i[i])
                    pend_q <= wdata_i;
                if (commit_i)
                    act_q <= pend_q;
                if (en_we_i[i])
                    en_q <= wdata_i[0];
            end
        end

        assign pending_o[i*DW +: DW] = pend_q;
        assign active_o[i*DW +: DW]  = act_q;
        assign en_o[i]               = en_q;
    end

endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen #(
    parameter int NUM_CH = 36,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic [NUM_CH-1:0]    en_i,
    input  logic [NUM_CH*DW-1:0] active_i,
    output logic [NUM_CH-1:0]    pwm_o
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        assign pwm_o[i] = run_i & en_i[i] & (cnt_q < active_i[i*DW +: DW]);
    end

endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
    import led_pwm_pkg::*;
#(
    parameter int NUM_CH      = 36,
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter bit REVERSED    = 1'b0,
    parameter int SHDN_ADDR   = ADDR_SHDN,
    parameter int DUTY_BASE   = ADDR_DUTY_BASE,
    parameter int COMMIT_ADDR = ADDR_COMMIT,
    parameter int EN_BASE     = ADDR_EN_BASE,
    parameter int GLOBAL_ADDR = ADDR_GLOBAL,
    parameter int CLEAR_ADDR  = ADDR_CLEAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [NUM_CH-1:0] pwm_o
);

    reg_kind_e            kind;
    logic [NUM_CH-1:0]    duty_sel;
    logic [NUM_CH-1:0]    en_sel;
    logic [NUM_CH*DW-1:0] pending_flat;
    logic [NUM_CH*DW-1:0] active_flat;
    logic [NUM_CH-1:0]    en_vec;
    logic                 do_clear;
    logic                 do_commit;
    logic                 run;
    mode_e                mode_q;
    mode_e                mode_d;

    led_reg_decode #(
        .NUM_CH(NUM_CH), .AW(AW), .REVERSED(REVERSED),
        .SHDN_ADDR(SHDN_ADDR), .DUTY_BASE(DUTY_BASE),
        .COMMIT_ADDR(COMMIT_ADDR), .EN_BASE(EN_BASE),
        .GLOBAL_ADDR(GLOBAL_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
    ) u_decode (
        .addr_i    (addr_i),
        .kind_o    (kind),
        .duty_sel_o(duty_sel),
        .en_sel_o  (en_sel)
    );

    assign do_clear  = wr_en_i && (kind == K_CLEAR);
    assign do_commit = wr_en_i && (kind == K_COMMIT);

    led_chan_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (do_clear),
        .commit_i (do_commit),
        .wdata_i  (wdata_i),
        .duty_we_i(duty_sel & {NUM_CH{wr_en_i && (kind == K_DUTY)}}),
        .en_we_i  (en_sel & {NUM_CH{wr_en_i && (kind == K_ENABLE)}}),
        .pending_o(pending_flat),
        .active_o (active_flat),
        .en_o     (en_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= ST_DARK;
        else
            mode_q <= mode_d;
    end

    // Next-state logic: clear, wake/sleep, mute/unmute
    always_comb begin
        mode_d = mode_q;
        if (do_clear) begin
            mode_d = ST_DARK;
        end else if (wr_en_i && (kind == K_SHDN)) begin
            unique case (mode_q)
                ST_DARK:       mode_d = wdata_i[0] ? ST_LIVE  : ST_DARK;
                ST_DARK_MUTED: mode_d = wdata_i[0] ? ST_MUTED : ST_DARK_MUTED;
                ST_LIVE:       mode_d = wdata_i[0] ? ST_LIVE  : ST_DARK;
                ST_MUTED:      mode_d = wdata_i[0] ? ST_MUTED : ST_DARK_MUTED;
                default:       mode_d = ST_DARK;
            endcase
        end else if (wr_en_i && (kind == K_GLOBAL)) begin
            unique case (mode_q)
                ST_DARK:       mode_d = wdata_i[0] ? ST_DARK_MUTED : ST_DARK;
                ST_DARK_MUTED: mode_d = wdata_i[0] ? ST_DARK_MUTED : ST_DARK;
                ST_LIVE:       mode_d = wdata_i[0] ? ST_MUTED      : ST_LIVE;
                ST_MUTED:      mode_d = wdata_i[0] ? ST_MUTED      : ST_LIVE;
                default:       mode_d = ST_DARK;
            endcase
        end
    end

    // Output logic
    always_comb begin
        run = (mode_q == ST_LIVE);
    end

    led_pwm_gen #(.NUM_CH(NUM_CH), .DW(DW)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .en_i    (en_vec),
        .active_i(active_flat),
        .pwm_o   (pwm_o)
    );

endmodule

// File: rtl/led_pwm_ctrl_chk.sv
module led_pwm_ctrl_chk #(
    parameter int NUM_CH      = 36,
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SHDN_ADDR   = 0,
    parameter int COMMIT_ADDR = 37,
    parameter int GLOBAL_ADDR = 74,
    parameter int CLEAR_ADDR  = 79
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [AW-1:0]        addr_i,
    input logic [DW-1:0]        wdata_i,
    input logic [NUM_CH-1:0]    pwm_o,
    input logic [NUM_CH*DW-1:0] pending_flat,
    input logic [NUM_CH*DW-1:0] active_flat,
    input logic [NUM_CH-1:0]    en_vec,
    input logic                 run
);

    // R3
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (addr_i == AW'(COMMIT_ADDR) || addr_i == AW'(CLEAR_ADDR)))
        |=> $stable(active_flat));

    // R6
    sleep_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(SHDN_ADDR) && !wdata_i[0]) |=> (pwm_o == '0));

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_o & ~en_vec) == '0));

    // R8
    mute_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(GLOBAL_ADDR) && wdata_i[0]) |=> (pwm_o == '0));

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(CLEAR_ADDR))
        |=> (pwm_o == '0 && pending_flat == '0 && active_flat == '0 && en_vec == '0));

    // R11
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i > AW'(GLOBAL_ADDR) && addr_i != AW'(CLEAR_ADDR))
        |=> ($stable(pending_flat) && $stable(active_flat) && $stable(en_vec) && $stable(run)));

endmodule

bind led_pwm_ctrl led_pwm_ctrl_chk #(
    .NUM_CH(NUM_CH), .AW(AW), .DW(DW),
    .SHDN_ADDR(SHDN_ADDR), .COMMIT_ADDR(COMMIT_ADDR),
    .GLOBAL_ADDR(GLOBAL_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .pwm_o       (pwm_o),
    .pending_flat(pending_flat),
    .active_flat (active_flat),
    .en_vec      (en_vec),
    .run         (run)
);

// File: tb/test_led_pwm_ctrl.sv
module test_led_pwm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 36;
    localparam int NREV = 4;

    typedef struct {
        int    which;
        int    ch;
        int    exp;
        string tag;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     addr = '0;
    logic [7:0]     wdata = '0;
    logic [NCH-1:0] pwm_main;
    logic [NREV-1:0] pwm_rev;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    meas_req = 1'b0;
    bit    done = 1'b0;
    item_t sb_q[$];
    int    cnt_main[NCH];
    int    cnt_rev[NREV];

    always #(CLK_PERIOD/2) clk = ~clk;

    led_pwm_ctrl i_led_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .pwm_o(pwm_main)
    );

    led_pwm_ctrl #(.NUM_CH(NREV), .REVERSED(1'b1)) i_led_pwm_ctrl_rev (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .pwm_o(pwm_rev)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hFF; wdata = '0;
    endtask

    task automatic expect_duty(input int which, input int ch, input int exp, input string tag);
        item_t it;
        it.which = which; it.ch = ch; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic measure();
        meas_req = 1'b1;
        wait (!meas_req);
    endtask

    // Monitor: counts high cycles over one full counter period, then scores
    initial begin
        forever begin
            wait (meas_req);
            for (int i = 0; i < NCH; i++) cnt_main[i] = 0;
            for (int i = 0; i < NREV; i++) cnt_rev[i] = 0;
            repeat (256) begin
                @(negedge clk);
                for (int i = 0; i < NCH; i++) cnt_main[i] += int'(pwm_main[i]);
                for (int i = 0; i < NREV; i++) cnt_rev[i] += int'(pwm_rev[i]);
            end
            while (sb_q.size() > 0) begin
                item_t it;
                int got;
                it = sb_q.pop_front();
                got = (it.which == 0) ? cnt_main[it.ch] : cnt_rev[it.ch];
                n_cmp++;
                if (got != it.exp) begin
                    n_bad++;
                    $display("FAIL %s: unit %0d ch %0d high count got %0d expected %0d",
                             it.tag, it.which, it.ch, got, it.exp);
                end
            end
            meas_req = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: reset state is dark
        expect_duty(0, 0, 0, "R10"); expect_duty(0, 35, 0, "R10");
        expect_duty(1, 3, 0, "R10");
        measure();

        // R10 / R7: enables default to zero
        wr(8'h00, 8'h01); wr(8'h01, 8'd100); wr(8'h25, 8'h00);
        expect_duty(0, 0, 0, "R7");
        measure();

        for (int i = 0; i < NCH; i++) wr(8'(8'h26 + i), 8'h01);
        // R1
        expect_duty(0, 0, 100, "R1"); expect_duty(0, 1, 0, "R1");
        measure();

        // R3: staged writes stay pending until commit
        wr(8'h02, 8'd50); wr(8'h24, 8'd200);
        expect_duty(0, 1, 0, "R3"); expect_duty(0, 35, 0, "R3");
        expect_duty(0, 0, 100, "R3");
        measure();
        wr(8'h25, 8'hA5);
        expect_duty(0, 1, 50, "R3"); expect_duty(0, 35, 200, "R3");
        measure();

        // R4: per-write commits versus one batch commit
        wr(8'h03, 8'd30); wr(8'h25, 8'h00); wr(8'h04, 8'd60); wr(8'h25, 8'h00);
        wr(8'h05, 8'd30); wr(8'h06, 8'd60); wr(8'h25, 8'h00);
        expect_duty(0, 2, 30, "R4"); expect_duty(0, 3, 60, "R4");
        expect_duty(0, 4, 30, "R4"); expect_duty(0, 5, 60, "R4");
        measure();

        // R5: duty extremes
        wr(8'h07, 8'd255); wr(8'h08, 8'd0); wr(8'h09, 8'd1); wr(8'h25, 8'h00);
        expect_duty(0, 6, 255, "R5"); expect_duty(0, 7, 0, "R5");
        expect_duty(0, 8, 1, "R5");
        // R2: reversed instance, address 0x01 feeds its last channel
        expect_duty(1, 3, 100, "R2"); expect_duty(1, 2, 50, "R2");
        expect_duty(1, 1, 30, "R2"); expect_duty(1, 0, 60, "R2");
        measure();

        // R7: enable bit 0 cleared, other bits set
        wr(8'h26, 8'hFE);
        expect_duty(0, 0, 0, "R7"); expect_duty(0, 1, 50, "R7");
        measure();
        wr(8'h26, 8'h01);

        // R8: global mute, then non-zero value with bit 0 clear
        wr(8'h4A, 8'h01);
        expect_duty(0, 0, 0, "R8"); expect_duty(0, 1, 0, "R8");
        measure();
        wr(8'h4A, 8'hFE);
        expect_duty(0, 1, 50, "R8"); expect_duty(0, 0, 100, "R8");
        measure();

        // R6: shutdown, wake with other bits set, hidden mute while dark
        wr(8'h00, 8'h00);
        expect_duty(0, 1, 0, "R6");
        measure();
        wr(8'h00, 8'hFF);
        expect_duty(0, 1, 50, "R6");
        measure();
        wr(8'h00, 8'h00); wr(8'h4A, 8'h01); wr(8'h00, 8'h01);
        expect_duty(0, 1, 0, "R6");
        measure();
        wr(8'h4A, 8'h00);
        expect_duty(0, 1, 50, "R6");
        measure();

        // R11: unmapped writes change nothing, not even pending bytes
        wr(8'h50, 8'h00); wr(8'hFF, 8'hFF); wr(8'h4C, 8'h00); wr(8'h4B, 8'h01);
        expect_duty(0, 1, 50, "R11"); expect_duty(0, 35, 200, "R11");
        measure();
        wr(8'h25, 8'h00);
        expect_duty(0, 1, 50, "R11"); expect_duty(0, 6, 255, "R11");
        measure();

        // R9: clear register wipes everything
        wr(8'h4F, 8'h12);
        expect_duty(0, 1, 0, "R9"); expect_duty(1, 3, 0, "R9");
        measure();
        wr(8'h00, 8'h01); wr(8'h27, 8'h01); wr(8'h25, 8'h00);
        expect_duty(0, 1, 0, "R9"); expect_duty(0, 6, 0, "R9");
        measure();
        wr(8'h02, 8'd77); wr(8'h25, 8'h00);
        expect_duty(0, 1, 77, "R9"); expect_duty(0, 0, 0, "R9");
        measure();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule